// File: doc/BRIEF.md
# Flash Page Address Translator

This block converts the location of a flash command, expressed in the controller's virtual page space, into the addresses that a bank built from two 8-bit NAND chips on a shared 16-bit bus actually needs. For each chip it produces the physical row address, or the pair of row addresses when two blocks are worked as twin planes. It also produces the physical column address for the source column and for a copy destination column, and the DRAM address at which the data transfer starts.

A sector-mode flag tells the block that columns are sector indices rather than byte offsets. Each sector then occupies 512 data bytes plus a configurable number of parity bytes, split evenly over the two chips. A twin-plane flag merges two neighbouring physical blocks into one virtual block. It also folds columns that fall past one physical page back into the second plane. The configuration comes from three inputs: physical page size, an encoded pages-per-block value and the parity bytes per sector. Each request is presented with a one-cycle strobe, and the translated result appears on registered outputs one clock later, together with a valid flag.

Top module: `nand_addr_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register, including `out_valid`, is cleared to zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the clock edge.
- R3: When `in_valid` is low at a clock edge, all address outputs keep their previous values, whatever the other inputs do.
- R4: With `two_plane`=0, both row outputs of a chip equal that chip's virtual row unchanged.
- R5: With `two_plane`=1 and P = 2^(5+`ppb_code`) pages per block, the first row is (row/P)*2*P + row%P and the second row is the first row plus P, both taken modulo 2^ROW_W.
- R6: The low-chip rows are derived only from `row_lo`, and the high-chip rows are derived only from `row_hi`.
- R7: With `sector_mode`=1, the intermediate column is floor(col*(512+`parity_bytes`)/2). With `two_plane`=0, that intermediate value is the physical column.
- R8: With `sector_mode`=0, the column is a byte offset. With `two_plane`=0, it passes through unchanged.
- R9: With `two_plane`=1, an intermediate column greater than or equal to `page_bytes` has `page_bytes` subtracted from it once. A smaller value is kept as is.
- R10: `dst_col` is converted to `pdst_col` by the same rules as `col`, under the same flags.
- R11: With `sector_mode`=1, `dma_start` is `dma_base` + 512*C, where C is `dst_col` when `copy_sel`=1 and `col` otherwise, modulo 2^DMA_W. With `sector_mode`=0, `dma_start` equals `dma_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| row_lo | input | ROW_W | Virtual row for the low chip |
| row_hi | input | ROW_W | Virtual row for the high chip |
| col | input | COL_W | Source column (sector index or byte offset) |
| dst_col | input | COL_W | Copy destination column |
| dma_base | input | DMA_W | DRAM buffer base address |
| sector_mode | input | 1 | 1: columns count sectors, DMA offset applied |
| two_plane | input | 1 | 1: block pairing and plane folding |
| copy_sel | input | 1 | 1: DMA offset taken from dst_col |
| page_bytes | input | PAGE_W | Physical page size in bytes (plane border) |
| ppb_code | input | PPB_W | Pages per block = 2^(5+code) |
| parity_bytes | input | PAR_W | Parity bytes per sector |
| out_valid | output | 1 | Result valid |
| prow_lo_a | output | ROW_W | Low chip first physical row |
| prow_lo_b | output | ROW_W | Low chip second physical row |
| prow_hi_a | output | ROW_W | High chip first physical row |
| prow_hi_b | output | ROW_W | High chip second physical row |
| pcol | output | COL_W+10 | Physical source column |
| pdst_col | output | COL_W+10 | Physical destination column |
| dma_start | output | DMA_W | DRAM transfer start address |

## Verification
The bench builds the block with its default widths: 32-bit rows and DMA addresses, 16-bit columns, a 16-bit page size, a 3-bit pages-per-block code and 8-bit parity counts. These values cover every block size from 32 to 4096 pages. They also let a row high in the 32-bit space show the wrap of the doubled block index. Sector columns large enough to cross one and two page widths are reachable, so the plane fold is seen both on its boundary and beyond it. A 32-bit base near the top of the address space shows the DMA offset wrapping.

// File: rtl/nax_pkg.sv
// Shared constants of the flash page address translator.
// Assumes 512-byte data sectors and a pages-per-block code offset of 5.
package nax_pkg;
    localparam int unsigned SECT_LOG2 = 9;
    localparam int unsigned SECT_BYTES = 1 << SECT_LOG2;
    localparam int unsigned PPB_BASE_LOG2 = 5;
    localparam int unsigned SECT_W = 10;
    localparam int unsigned NUM_CHIPS = 2;

    typedef enum logic {
        CHIP_LO = 1'b0,
        CHIP_HI = 1'b1
    } chip_e;
endpackage

// File: rtl/nax_row_map.sv
// Row mapper for one chip: passes the virtual row through, or in twin-plane
// mode spreads it over a pair of neighbouring physical blocks.
// Assumes pages per block is 2^(PPB_BASE_LOG2 + ppb_code); results wrap at ROW_W.
module nax_row_map #(
    parameter int ROW_W = 32,
    parameter int PPB_W = 3
) (
    input  logic [ROW_W-1:0] vrow,
    input  logic             two_plane,
    input  logic [PPB_W-1:0] ppb_code,
    output logic [ROW_W-1:0] prow_a,
    output logic [ROW_W-1:0] prow_b
);
    import nax_pkg::*;

    logic [ROW_W-1:0] ppb;
    logic [ROW_W-1:0] off_mask;
    logic [ROW_W-1:0] paired;

    // Block size and in-block offset mask from the encoded field.
    always_comb begin
        ppb      = ROW_W'(1) << (PPB_BASE_LOG2 + int'(ppb_code));
        off_mask = ppb - ROW_W'(1);
    end

    // Doubling the block index leaves a gap block for the second plane.
    always_comb begin
        paired = ((vrow & ~off_mask) << 1) | (vrow & off_mask);
    end

    // Select pass-through or paired rows.
    always_comb begin
        if (two_plane) begin
            prow_a = paired;
            prow_b = paired + ppb;
        end else begin
            prow_a = vrow;
            prow_b = vrow;
        end
    end
endmodule

// File: rtl/nax_col_map.sv
// Column mapper: scales a sector index by the per-chip sector footprint
// (data plus parity, halved across the two chips) and folds columns in the
// second plane back by one physical page.
// Assumes parity bytes per sector fit below 512 so the footprint fits SECT_W bits.
module nax_col_map #(
    parameter int COL_W  = 16,
    parameter int PAGE_W = 16,
    parameter int PAR_W  = 8,
    parameter int PCOL_W = COL_W + 10
) (
    input  logic [COL_W-1:0]  vcol,
    input  logic              sector_mode,
    input  logic              two_plane,
    input  logic [PAGE_W-1:0] page_bytes,
    input  logic [PAR_W-1:0]  parity_bytes,
    output logic [PCOL_W-1:0] pcol
);
    import nax_pkg::*;

    logic [SECT_W-1:0] sect_span;
    logic [PCOL_W-1:0] prod;
    logic [PCOL_W-1:0] inter;
    logic [PCOL_W-1:0] page_ext;

    // Bytes that one sector occupies across both chips.
    always_comb begin
        sect_span = SECT_W'(SECT_BYTES) + SECT_W'(parity_bytes);
        prod      = PCOL_W'(vcol) * PCOL_W'(sect_span);
    end

    // Intermediate column: halved sector footprint or raw byte offset.
    always_comb begin
        if (sector_mode) begin
            inter = prod >> 1;
        end else begin
            inter = PCOL_W'(vcol);
        end
    end

    // Second-plane fold against the physical page border.
    always_comb begin
        page_ext = PCOL_W'(page_bytes);
        if (two_plane && (inter >= page_ext)) begin
            pcol = inter - page_ext;
        end else begin
            pcol = inter;
        end
    end
endmodule

// File: rtl/nax_dma_calc.sv
// DMA start address: base plus whole sectors of the selected column when in
// sector mode, else the base alone. Assumes DMA_W >= COL_W; wraps at DMA_W.
module nax_dma_calc #(
    parameter int COL_W = 16,
    parameter int DMA_W = 32
) (
    input  logic [DMA_W-1:0] dma_base,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] dst_col,
    input  logic             copy_sel,
    input  logic             sector_mode,
    output logic [DMA_W-1:0] dma_start
);
    import nax_pkg::*;

    logic [COL_W-1:0] sel_col;
    logic [DMA_W-1:0] byte_off;

    // Pick the column whose sectors offset the transfer.
    always_comb begin
        sel_col  = copy_sel ? dst_col : col;
        byte_off = DMA_W'(sel_col) << SECT_LOG2;
    end

    // Apply the offset only for sector-indexed transfers.
    always_comb begin
        dma_start = sector_mode ? (dma_base + byte_off) : dma_base;
    end
endmodule

// File: rtl/nand_addr_xlate.sv
// Top of the flash page address translator. Captures one request per
// in_valid strobe and presents the translated rows, columns and DMA start on
// registers one cycle later with out_valid. Outputs hold between requests.
// Assumes the configuration inputs are stable while in_valid is high.
module nand_addr_xlate #(
    parameter int ROW_W  = 32,
    parameter int COL_W  = 16,
    parameter int DMA_W  = 32,
    parameter int PAGE_W = 16,
    parameter int PPB_W  = 3,
    parameter int PAR_W  = 8,
    localparam int PCOL_W = COL_W + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ROW_W-1:0]  row_lo,
    input  logic [ROW_W-1:0]  row_hi,
    input  logic [COL_W-1:0]  col,
    input  logic [COL_W-1:0]  dst_col,
    input  logic [DMA_W-1:0]  dma_base,
    input  logic              sector_mode,
    input  logic              two_plane,
    input  logic              copy_sel,
    input  logic [PAGE_W-1:0] page_bytes,
    input  logic [PPB_W-1:0]  ppb_code,
    input  logic [PAR_W-1:0]  parity_bytes,
    output logic              out_valid,
    output logic [ROW_W-1:0]  prow_lo_a,
    output logic [ROW_W-1:0]  prow_lo_b,
    output logic [ROW_W-1:0]  prow_hi_a,
    output logic [ROW_W-1:0]  prow_hi_b,
    output logic [PCOL_W-1:0] pcol,
    output logic [PCOL_W-1:0] pdst_col,
    output logic [DMA_W-1:0]  dma_start
);
    import nax_pkg::*;

    logic [ROW_W-1:0]  vrow   [NUM_CHIPS];
    logic [ROW_W-1:0]  nrow_a [NUM_CHIPS];
    logic [ROW_W-1:0]  nrow_b [NUM_CHIPS];
    logic [COL_W-1:0]  vcols  [2];
    logic [PCOL_W-1:0] ncols  [2];
    logic [DMA_W-1:0]  ndma;

    // Route each chip's virtual row to its mapper.
    always_comb begin
        vrow[CHIP_LO] = row_lo;
        vrow[CHIP_HI] = row_hi;
        vcols[0]      = col;
        vcols[1]      = dst_col;
    end

    // One row mapper per chip.
    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        nax_row_map #(
            .ROW_W (ROW_W),
            .PPB_W (PPB_W)
        ) u_row (
            .vrow      (vrow[c]),
            .two_plane (two_plane),
            .ppb_code  (ppb_code),
            .prow_a    (nrow_a[c]),
            .prow_b    (nrow_b[c])
        );
    end

    // One column mapper each for source and destination columns.
    for (genvar k = 0; k < 2; k++) begin : g_col
        nax_col_map #(
            .COL_W  (COL_W),
            .PAGE_W (PAGE_W),
            .PAR_W  (PAR_W),
            .PCOL_W (PCOL_W)
        ) u_col (
            .vcol         (vcols[k]),
            .sector_mode  (sector_mode),
            .two_plane    (two_plane),
            .page_bytes   (page_bytes),
            .parity_bytes (parity_bytes),
            .pcol         (ncols[k])
        );
    end

    nax_dma_calc #(
        .COL_W (COL_W),
        .DMA_W (DMA_W)
    ) u_dma (
        .dma_base    (dma_base),
        .col         (col),
        .dst_col     (dst_col),
        .copy_sel    (copy_sel),
        .sector_mode (sector_mode),
        .dma_start   (ndma)
    );

    // Output register stage: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            prow_lo_a <= '0;
            prow_lo_b <= '0;
            prow_hi_a <= '0;
            prow_hi_b <= '0;
            pcol      <= '0;
            pdst_col  <= '0;
            dma_start <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prow_lo_a <= nrow_a[CHIP_LO];
                prow_lo_b <= nrow_b[CHIP_LO];
                prow_hi_a <= nrow_a[CHIP_HI];
                prow_hi_b <= nrow_b[CHIP_HI];
                pcol      <= ncols[0];
                pdst_col  <= ncols[1];
                dma_start <= ndma;
            end
        end
    end
endmodule

// File: rtl/nand_addr_xlate_chk.sv
// Property checker for the flash page address translator, bound to the top.
// Observes ports only; relates each result to the inputs of the prior cycle.
module nand_addr_xlate_chk #(
    parameter int ROW_W  = 32,
    parameter int COL_W  = 16,
    parameter int DMA_W  = 32,
    parameter int PAGE_W = 16,
    parameter int PPB_W  = 3,
    parameter int PAR_W  = 8,
    localparam int PCOL_W = COL_W + 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ROW_W-1:0]  row_lo,
    input logic [ROW_W-1:0]  row_hi,
    input logic [COL_W-1:0]  col,
    input logic [DMA_W-1:0]  dma_base,
    input logic              sector_mode,
    input logic              two_plane,
    input logic [PPB_W-1:0]  ppb_code,
    input logic              out_valid,
    input logic [ROW_W-1:0]  prow_lo_a,
    input logic [ROW_W-1:0]  prow_lo_b,
    input logic [ROW_W-1:0]  prow_hi_a,
    input logic [ROW_W-1:0]  prow_hi_b,
    input logic [PCOL_W-1:0] pcol,
    input logic [PCOL_W-1:0] pdst_col,
    input logic [DMA_W-1:0]  dma_start
);
    import nax_pkg::*;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(prow_lo_a) && $stable(prow_lo_b) &&
                       $stable(prow_hi_a) && $stable(prow_hi_b) &&
                       $stable(pcol) && $stable(pdst_col) && $stable(dma_start)));

    // R4
    row_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !two_plane) |=>
            (prow_lo_a == $past(row_lo) && prow_lo_b == $past(row_lo) &&
             prow_hi_a == $past(row_hi) && prow_hi_b == $past(row_hi)));

    // R5
    row_pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && two_plane) |=>
            (prow_lo_b - prow_lo_a == ROW_W'(1) << (PPB_BASE_LOG2 + int'($past(ppb_code))) &&
             prow_hi_b - prow_hi_a == ROW_W'(1) << (PPB_BASE_LOG2 + int'($past(ppb_code)))));

    // R8
    col_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sector_mode && !two_plane) |=> pcol == PCOL_W'($past(col)));

    // R11
    dma_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sector_mode) |=> dma_start == $past(dma_base));
endmodule

bind nand_addr_xlate nand_addr_xlate_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DMA_W  (DMA_W),
    .PAGE_W (PAGE_W),
    .PPB_W  (PPB_W),
    .PAR_W  (PAR_W)
) u_chk (.*);

// File: tb/nand_addr_xlate_test.sv
// Bench for the flash page address translator: a behavioural reference
// model updated on every rising edge and compared on every falling edge.
module nand_addr_xlate_test;
    localparam int ROW_W = 32, COL_W = 16, DMA_W = 32, PAGE_W = 16, PPB_W = 3, PAR_W = 8;
    localparam int PCOL_W = COL_W + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [ROW_W-1:0] row_lo = '0, row_hi = '0;
    logic [COL_W-1:0] col = '0, dst_col = '0;
    logic [DMA_W-1:0] dma_base = '0;
    logic sector_mode = 1'b0, two_plane = 1'b0, copy_sel = 1'b0;
    logic [PAGE_W-1:0] page_bytes = '0;
    logic [PPB_W-1:0] ppb_code = '0;
    logic [PAR_W-1:0] parity_bytes = '0;
    logic out_valid;
    logic [ROW_W-1:0] prow_lo_a, prow_lo_b, prow_hi_a, prow_hi_b;
    logic [PCOL_W-1:0] pcol, pdst_col;
    logic [DMA_W-1:0] dma_start;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    nand_addr_xlate uut (.*);

    // Reference model state
    longint e_valid = 0, e_la = 0, e_lb = 0, e_ha = 0, e_hb = 0, e_col = 0, e_dst = 0, e_dma = 0;
    bit m_loaded = 0, m_tp = 0, m_ecc = 0, m_rst = 1;

    function automatic longint map_col(longint c, bit ecc, bit tp, longint pg, longint par);
        longint t;
        t = ecc ? (c * (512 + par)) / 2 : c;
        if (tp && t >= pg) t = t - pg;
        return t;
    endfunction

    task automatic row_map(input longint r, input bit tp, input longint code,
                           output longint a, output longint b);
        longint p;
        p = longint'(1) << (5 + code);
        if (tp) begin
            a = ((r / p) * 2 * p + (r % p)) % (longint'(1) << ROW_W);
            b = (a + p) % (longint'(1) << ROW_W);
        end else begin
            a = r;
            b = r;
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        m_rst = !rst_n;
        if (!rst_n) begin
            e_valid = 0; e_la = 0; e_lb = 0; e_ha = 0; e_hb = 0; e_col = 0; e_dst = 0; e_dma = 0;
            m_loaded = 0;
        end else begin
            e_valid = in_valid;
            m_loaded = in_valid;
            if (in_valid) begin
                m_tp = two_plane;
                m_ecc = sector_mode;
                row_map(longint'(row_lo), two_plane, longint'(ppb_code), e_la, e_lb);
                row_map(longint'(row_hi), two_plane, longint'(ppb_code), e_ha, e_hb);
                e_col = map_col(longint'(col), sector_mode, two_plane, longint'(page_bytes), longint'(parity_bytes));
                e_dst = map_col(longint'(dst_col), sector_mode, two_plane, longint'(page_bytes), longint'(parity_bytes));
                e_dma = sector_mode ?
                    (longint'(dma_base) + 512 * longint'(copy_sel ? dst_col : col)) % (longint'(1) << DMA_W)
                    : longint'(dma_base);
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            string rrow, rhi, rcol, rdst, rdma, rv;
            if (m_rst) begin
                rrow = "R1"; rhi = "R1"; rcol = "R1"; rdst = "R1"; rdma = "R1"; rv = "R1";
            end else if (!m_loaded) begin
                rrow = "R3"; rhi = "R3"; rcol = "R3"; rdst = "R3"; rdma = "R3"; rv = "R2";
            end else begin
                rrow = m_tp ? "R5" : "R4";
                rhi = "R6";
                rcol = m_ecc ? (m_tp ? "R9" : "R7") : (m_tp ? "R9" : "R8");
                rdst = "R10";
                rdma = "R11";
                rv = "R2";
            end
            chk(rv, "out_valid", longint'(out_valid), e_valid);
            chk(rrow, "prow_lo_a", longint'(prow_lo_a), e_la);
            chk(rrow, "prow_lo_b", longint'(prow_lo_b), e_lb);
            chk(rhi, "prow_hi_a", longint'(prow_hi_a), e_ha);
            chk(rhi, "prow_hi_b", longint'(prow_hi_b), e_hb);
            chk(rcol, "pcol", longint'(pcol), e_col);
            chk(rdst, "pdst_col", longint'(pdst_col), e_dst);
            chk(rdma, "dma_start", longint'(dma_start), e_dma);
        end
    end

    task automatic send(input logic [ROW_W-1:0] rl, input logic [ROW_W-1:0] rh,
                        input logic [COL_W-1:0] c, input logic [COL_W-1:0] dc,
                        input logic [DMA_W-1:0] base, input bit ecc, input bit tp,
                        input bit cp, input logic [PAGE_W-1:0] pg,
                        input logic [PPB_W-1:0] code, input logic [PAR_W-1:0] par);
        in_valid = 1'b1; row_lo = rl; row_hi = rh; col = c; dst_col = dc; dma_base = base;
        sector_mode = ecc; two_plane = tp; copy_sel = cp; page_bytes = pg; ppb_code = code;
        parity_bytes = par;
        @(negedge clk);
    endtask

    // Idle cycle with scrambled inputs to show they are ignored (R3).
    task automatic idle_noise();
        in_valid = 1'b0;
        row_lo = $urandom; row_hi = $urandom; col = COL_W'($urandom); dst_col = COL_W'($urandom);
        dma_base = $urandom; sector_mode = 1'($urandom); two_plane = 1'($urandom);
        copy_sel = 1'($urandom); ppb_code = PPB_W'($urandom);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 / R8 / R11 plain passthrough
        send(32'd1234, 32'd98765, 16'd300, 16'd7, 32'h0010_0000, 0, 0, 0, 16'd2048, 3'd0, 8'd16);
        idle_noise();
        // R5 / R6: row 37 with 32-page blocks gives 69 and 101; high chip differs
        send(32'd37, 32'd4095, 16'd4, 16'd8, 32'h0020_0000, 1, 1, 0, 16'd2048, 3'd0, 8'd16);
        // R9 fold: col 8 -> 2112 >= 2048 -> 64; R10 dst and R11 copy offset
        send(32'd37, 32'd5, 16'd8, 16'd4, 32'h0020_0000, 1, 1, 1, 16'd2048, 3'd0, 8'd16);
        // R7 odd product floor: 3*535/2 = 802
        send(32'd1000, 32'd2000, 16'd3, 16'd1, 32'hFFFF_FF00, 1, 0, 0, 16'd4096, 3'd2, 8'd23);
        // R9 boundary: intermediate exactly equal to page
        send(32'd0, 32'hFFFF_FFFF, 16'd2048, 16'd2047, 32'h0, 0, 1, 0, 16'd2048, 3'd7, 8'd0);
        idle_noise();
        idle_noise();
        // R5 high-row wrap and largest block size
        send(32'hFFFF_F123, 32'h8000_0FFF, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 1, 1, 1, 16'hFFFF, 3'd7, 8'hFF);
        for (int i = 0; i < 400; i++) begin
            if ((i % 5) == 4) idle_noise();
            else send($urandom, $urandom, COL_W'($urandom_range(0, 200)), COL_W'($urandom_range(0, 200)),
                      $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                      PAGE_W'($urandom_range(512, 16384)), PPB_W'($urandom), PAR_W'($urandom));
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset clears registers mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule